// File: doc/BRIEF.md
# Write-Only I2C Register Programming Slave

This block receives control settings over a two-wire I2C bus and presents them as parallel registers to a frequency synthesiser. It runs on a fast system clock that oversamples SCL and SDA. A message is a device address byte, then a sub-address byte that picks one of four register groups, then the data bytes for that group. The slave acknowledges each accepted byte by pulling SDA low through an open-drain enable.

Received data waits in a holding shift register. The output registers change only when the message ends with a STOP or a repeated START, and only when the message was well formed. A message that is cut short, too long, or has the wrong byte count leaves every output register as it was. Bit 7 of the address comes from an external select pin. Two of these slaves can therefore share one bus.

Top module: `i2c_prog_slave`

## Requirements
- R1: SCL and SDA pass through a two-stage synchronizer. A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high.
- R2: SDA is sampled on each rising SCL edge. Bytes arrive most significant bit first.
- R3: An address byte is accepted only when bit 7 equals `sd_pin`, bits 6:1 equal `DEV_ADDR`, and bit 0 is 0. Any other address is not acknowledged, and all bytes up to the next START are ignored and not acknowledged.
- R4: For an accepted byte, `sda_oe` goes high after the SCL falling edge that ends the 8th bit. It goes low after the next SCL falling edge. It is never high while a data bit is being clocked.
- R5: Bits 1:0 of the sub-address select a group: 0 is `reg_a` with 1 byte, 1 is `reg_b` with 2 bytes, 2 is `reg_c` with 3 bytes, and 3 is `reg_d` with 2 bytes. The first data byte lands in the most significant byte.
- R6: A group register is written only when a STOP or START ends a message whose count of complete data bytes equals that group's count. Otherwise no register changes.
- R7: A fourth data byte is not acknowledged, and the whole message is discarded.
- R8: A repeated START commits the message before it and restarts address reception. A START in the middle of a byte aborts that byte, and the bytes already completed still count.
- R9: Reset clears all output registers, returns the receiver to idle, and deasserts `sda_oe`.
- R10: Between bus conditions, the output registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | Bus serial clock |
| sda_in | input | 1 | Bus data level as seen on the wire |
| sd_pin | input | 1 | Expected value of address bit 7 |
| sda_oe | output | 1 | When high, the pad pulls SDA low (acknowledge) |
| reg_a | output | 8 | Group 0 register |
| reg_b | output | 16 | Group 1 register |
| reg_c | output | 24 | Group 2 register |
| reg_d | output | 16 | Group 3 register |

## Verification
A wrong bit count or phase shows first on the bus. The acknowledge appears on the wrong clock, or is missing or extra, within one byte time of the fault. A wrong group choice, byte order or count check shows at the register outputs within a few system clocks after the STOP or START that ends the message. The bench therefore samples the acknowledge for every byte and compares all four registers after every message. It sweeps both select levels, all four groups, and data counts from zero to four.

// File: rtl/i2c_prog_slave.sv
module i2c_prog_slave #(
  parameter logic [5:0] DEV_ADDR = 6'b100110
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl,
  input  logic        sda_in,
  input  logic        sd_pin,
  output logic        sda_oe,
  output logic [7:0]  reg_a,
  output logic [15:0] reg_b,
  output logic [23:0] reg_c,
  output logic [15:0] reg_d
);
  typedef enum logic [2:0] {P_IDLE, P_ADDR, P_SUB, P_DATA, P_SKIP} phase_t;

  phase_t      phase;
  logic [2:0]  scl_q, sda_q;
  logic [3:0]  bitcnt;
  logic [7:0]  shreg;
  logic [23:0] hold;
  logic [1:0]  grp, nbytes;
  logic        ack_pend;

  wire scl_r = scl_q[1];
  wire scl_d = scl_q[2];
  wire sda_r = sda_q[1];
  wire sda_d = sda_q[2];

  wire start_c  = scl_r & scl_d & sda_d & ~sda_r;
  wire stop_c   = scl_r & scl_d & ~sda_d & sda_r;
  wire scl_rise = scl_r & ~scl_d;
  wire scl_fall = ~scl_r & scl_d;

  wire [7:0] byte_w  = {shreg[6:0], sda_r};
  wire       addr_ok = (byte_w[7] == sd_pin) && (byte_w[6:1] == DEV_ADDR) && !byte_w[0];
  wire       active  = (phase == P_ADDR) || (phase == P_SUB) || (phase == P_DATA);

  function automatic logic [1:0] need(input logic [1:0] g);
    case (g)
      2'd0:    need = 2'd1;
      2'd2:    need = 2'd3;
      default: need = 2'd2;
    endcase
  endfunction

  wire commit_ok = (phase == P_DATA) && (nbytes == need(grp));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl};
      sda_q <= {sda_q[1:0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= P_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      hold     <= '0;
      grp      <= '0;
      nbytes   <= '0;
      ack_pend <= 1'b0;
      sda_oe   <= 1'b0;
      reg_a    <= '0;
      reg_b    <= '0;
      reg_c    <= '0;
      reg_d    <= '0;
    end else if (start_c || stop_c) begin
      if (commit_ok) begin
        case (grp)
          2'd0:    reg_a <= hold[7:0];
          2'd1:    reg_b <= hold[15:0];
          2'd2:    reg_c <= hold;
          default: reg_d <= hold[15:0];
        endcase
      end
      phase    <= start_c ? P_ADDR : P_IDLE;
      bitcnt   <= '0;
      nbytes   <= '0;
      ack_pend <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (active) begin
      if (scl_rise && bitcnt < 4'd8) begin
        shreg  <= byte_w;
        bitcnt <= bitcnt + 4'd1;
        if (bitcnt == 4'd7) begin
          ack_pend <= 1'b1;
          case (phase)
            P_ADDR: if (!addr_ok) begin
                      phase    <= P_SKIP;
                      ack_pend <= 1'b0;
                    end else phase <= P_SUB;
            P_SUB: begin
              grp    <= byte_w[1:0];
              nbytes <= '0;
              phase  <= P_DATA;
            end
            default: if (nbytes == 2'd3) begin
                       phase    <= P_SKIP;
                       ack_pend <= 1'b0;
                     end else begin
                       hold   <= {hold[15:0], byte_w};
                       nbytes <= nbytes + 2'd1;
                     end
          endcase
        end
      end else if (scl_fall && bitcnt == 4'd8) begin
        sda_oe <= ack_pend;
        bitcnt <= 4'd9;
      end else if (scl_fall && bitcnt == 4'd9) begin
        sda_oe   <= 1'b0;
        bitcnt   <= '0;
        ack_pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2c_prog_slave_chk.sv
module i2c_prog_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sda_oe,
  input logic        scl_lvl,
  input logic        start_det,
  input logic        stop_det,
  input logic        idle,
  input logic [3:0]  bitcnt,
  input logic [7:0]  reg_a,
  input logic [15:0] reg_b,
  input logic [23:0] reg_c,
  input logic [15:0] reg_d
);
  assert_oe_in_ack_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> bitcnt == 4'd9);

  assert_oe_rise_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl);

  assert_regs_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_det || stop_det) |=> $stable({reg_a, reg_b, reg_c, reg_d}));

  assert_one_group_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_a != $past(reg_a), reg_b != $past(reg_b),
              reg_c != $past(reg_c), reg_d != $past(reg_d)}));

  assert_idle_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_oe);

  assert_reset_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ({reg_a, reg_b, reg_c, reg_d} == '0 && !sda_oe));
endmodule

bind i2c_prog_slave i2c_prog_slave_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_lvl(scl_r),
  .start_det(start_c), .stop_det(stop_c), .idle(phase == P_IDLE),
  .bitcnt(bitcnt), .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c), .reg_d(reg_d)
);

// File: tb/i2c_prog_slave_tb.sv
module i2c_prog_slave_tb_top;
  localparam int HALF = 8;
  localparam logic [5:0] DEV = 6'b100110;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1, sd_pin = 1'b0;
  logic sda_oe;
  logic [7:0] reg_a;
  logic [15:0] reg_b, reg_d;
  logic [23:0] reg_c;
  wire sda_bus = m_sda & ~sda_oe;

  logic [7:0] ea = '0;
  logic [15:0] eb = '0, ed = '0;
  logic [23:0] ec = '0;
  int checks = 0, fails = 0, oe_early = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  i2c_prog_slave #(.DEV_ADDR(DEV)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sda_in(sda_bus), .sd_pin(sd_pin),
    .sda_oe(sda_oe), .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c), .reg_d(reg_d));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic hw();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bstart();
    m_sda = 1'b1; hw(); scl = 1'b1; hw(); m_sda = 1'b0; hw(); scl = 1'b0; hw();
  endtask

  task automatic bstop();
    m_sda = 1'b0; hw(); scl = 1'b1; hw(); m_sda = 1'b1; hw(); hw();
  endtask

  task automatic sbyte(input logic [7:0] b, input int nbits, output bit ack);
    ack = 1'b0;
    for (int i = 7; i > 7 - nbits; i--) begin
      m_sda = b[i]; hw(); scl = 1'b1; hw();
      if (sda_oe) oe_early++;
      scl = 1'b0;
    end
    if (nbits == 8) begin
      m_sda = 1'b1; hw(); scl = 1'b1; hw();
      ack = (sda_bus == 1'b0);
      scl = 1'b0; hw();
    end
  endtask

  function automatic logic [7:0] dbyte(input int g, input int k, input int i);
    return 8'((g * 53 + k * 29 + i * 101 + 7) & 255);
  endfunction

  function automatic int need(input int g);
    return (g == 0) ? 1 : (g == 2) ? 3 : 2;
  endfunction

  task automatic send_msg(input logic [7:0] addr, input int g, input int n, input int k, output int mask);
    bit a;
    mask = 0;
    sbyte(addr, 8, a); mask |= int'(a);
    sbyte(8'(g), 8, a); mask |= int'(a) << 1;
    for (int i = 0; i < n; i++) begin
      sbyte(dbyte(g, k, i), 8, a); mask |= int'(a) << (i + 2);
    end
  endtask

  task automatic model(input int g, input int k);
    case (g)
      0: ea = dbyte(g, k, 0);
      1: eb = {dbyte(g, k, 0), dbyte(g, k, 1)};
      2: ec = {dbyte(g, k, 0), dbyte(g, k, 1), dbyte(g, k, 2)};
      default: ed = {dbyte(g, k, 0), dbyte(g, k, 1)};
    endcase
  endtask

  task automatic cmp_regs(input string req);
    chk(reg_a == ea, {req, " reg_a"}, 64'(reg_a), 64'(ea));
    chk(reg_b == eb, {req, " reg_b"}, 64'(reg_b), 64'(eb));
    chk(reg_c == ec, {req, " reg_c"}, 64'(reg_c), 64'(ec));
    chk(reg_d == ed, {req, " reg_d"}, 64'(reg_d), 64'(ed));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int mask, expm, k;
    bit a;
    logic [7:0] good;
    hw();
    // R9: reset state
    cmp_regs("R9 reset");
    chk(sda_oe == 1'b0, "R9 sda_oe in reset", 64'(sda_oe), 0);
    rst_n = 1'b1; hw();

    // R1 R2 R3 R4 R5 R6 R7 R10: sweep select level, group and data count
    for (int sp = 0; sp < 2; sp++) begin
      sd_pin = 1'(sp);
      good = {1'(sp), DEV, 1'b0};
      for (int g = 0; g < 4; g++) begin
        for (int n = 0; n <= 4; n++) begin
          k = sp * 5 + n;
          bstart();
          send_msg(good, g, n, k, mask);
          expm = 3;
          for (int i = 0; i < n && i < 3; i++) expm |= 1 << (i + 2);
          chk(mask == expm, "R3 R4 R7 ack pattern", 64'(mask), 64'(expm));
          bstop();
          if (n == need(g)) model(g, k);
          cmp_regs("R2 R5 R6 R7 R10 after stop");
        end
      end
    end

    // R3: each single-bit address error is refused and changes nothing
    sd_pin = 1'b1;
    good = {1'b1, DEV, 1'b0};
    for (int b = 0; b < 8; b++) begin
      bstart();
      send_msg(good ^ (8'd1 << b), 2, 3, 40 + b, mask);
      chk(mask == 0, "R3 bad address no ack", 64'(mask), 0);
      bstop();
      cmp_regs("R3 R10 bad address");
    end

    // R8: repeated START commits the previous message without STOP
    bstart();
    send_msg(good, 1, 2, 50, mask);
    bstart();
    model(1, 50);
    cmp_regs("R8 commit on repeated start");
    send_msg(good, 2, 3, 51, mask);
    chk(mask == 31, "R8 ack after repeated start", 64'(mask), 31);
    bstop();
    model(2, 51);
    cmp_regs("R8 second message");

    // R8: START in the middle of a byte aborts it; completed bytes still count
    bstart();
    send_msg(good, 0, 1, 52, mask);
    sbyte(8'hA5, 4, a);
    bstart();
    model(0, 52);
    cmp_regs("R8 mid-byte start commits whole bytes");
    send_msg(good, 3, 2, 53, mask);
    chk(mask == 15, "R1 R8 address restarted", 64'(mask), 15);
    bstop();
    model(3, 53);
    cmp_regs("R8 after abort");

    // R6: data cut mid-byte leaves count short, so nothing is written
    bstart();
    send_msg(good, 2, 2, 54, mask);
    sbyte(8'h3C, 5, a);
    bstart();
    bstop();
    cmp_regs("R6 short count discarded");

    chk(oe_early == 0, "R4 sda_oe during data bits", 64'(oe_early), 0);

    // R9: reset mid-run clears outputs
    rst_n = 1'b0; hw();
    ea = '0; eb = '0; ec = '0; ed = '0;
    cmp_regs("R9 reset again");
    chk(sda_oe == 1'b0, "R9 sda_oe after reset", 64'(sda_oe), 0);
    rst_n = 1'b1; hw();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule